// File: doc/BRIEF.md
# Cubic Hermite Quarter-Wave Sine Interpolator

This block turns a quarter-wave position into a signed sine sample. A phase stage upstream supplies the index of the interval that holds the phase, a second index used to fetch slopes, a fractional offset inside the interval and a sign bit. The block does no phase folding of its own. It evaluates a cubic Hermite polynomial between the two interval nodes and returns a 14-bit two's-complement sample four cycles later.

Only one table is stored: the magnitude of sine at the nodes of one quarter wave. The slope of sine at a node is the cosine there, and that equals the sine of the mirrored node. A second read port on the same table therefore supplies the slopes, and no derivative table is needed. Each word holds both nodes of one interval. The two halves are split after the read, so one fetch per port gives two values or two slopes. The table is filled from series-evaluated sine constants when the design is elaborated.

A new input can be accepted on every clock. The valid flag and the sign travel through the pipeline with the data.

Top module: `hermite_sine_interp`

## Requirements
- R1: With a zero fractional offset, the output magnitude equals node value `round(8191*sin(k*pi/(2N)))` for value index k exactly. N is the number of intervals, 16 by default.
- R2: When the slope index is the mirror of the value index (N-1-k), the output is within 2 LSB of `round(8191*sin((k+f/2^FRAC_W)*pi/(2N)))` for every offset f.
- R3: Table word j holds node j in its low 13 bits and node j+1 in its high 13 bits. The value port reads word k: node k is y0 and node k+1 is y1. The slope port reads word s: the high half gives the start slope and the low half gives the end slope. Each slope half is scaled by the interval width pi/(2N). The output follows this Hermite polynomial within 2 LSB for any slope index.
- R4: A set sign input negates the result: the output is minus the magnitude the same inputs give with the sign clear.
- R5: The magnitude is clamped to the range [0, 8191] before the sign is applied, so the output never leaves [-8191, 8191].
- R6: out_valid rises exactly 4 clock cycles after an accepted in_valid. Inputs may arrive on consecutive cycles.
- R7: While reset is held and right after it, out_valid is 0 and out_sample is 0.
- R8: out_sample holds its last value on cycles where out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input qualifier |
| in_val_addr | input | NODE_BITS | Interval index k for the node values |
| in_slope_addr | input | NODE_BITS | Table word index used for the slopes |
| in_frac | input | FRAC_W | Offset inside the interval, unsigned fraction |
| in_neg | input | 1 | Negate the result |
| out_valid | output | 1 | Output qualifier |
| out_sample | output | OUT_W | Signed sample |

## Verification
The bench builds the block with its defaults: 16 intervals, a 10-bit fraction and a 14-bit output. With only 16 intervals, a run can visit every node and every interval, including the peak interval where the clamp matters. Mismatched slope indices are fed on purpose to push the polynomial above full scale, which exercises the clamp and the layout of the packed words. A back-to-back burst checks the pipeline spacing, and an idle gap checks the hold behaviour.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  localparam real PI_R = 3.14159265358979323846;

  // odd power series, accurate well below one LSB on [0, pi/2]
  function automatic real series_sin(real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int i = 1; i < 10; i++) begin
      term = -term * x * x / (real'(2 * i) * real'(2 * i + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic int node_code(int k, int n, int full);
    return int'(series_sin(PI_R * real'(k) / (2.0 * real'(n))) * real'(full));
  endfunction

  function automatic int width_code(int n, int frac_bits);
    real scale;
    scale = 1.0;
    for (int i = 0; i < frac_bits; i++) scale = scale * 2.0;
    return int'(PI_R / (2.0 * real'(n)) * scale);
  endfunction
endpackage

// File: rtl/hsi_qrom.sv
module hsi_qrom #(
  parameter int NODE_BITS = 4,
  parameter int AMP_W     = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [NODE_BITS-1:0]   addr_a,
  input  logic [NODE_BITS-1:0]   addr_b,
  output logic [2*AMP_W-1:0]     word_a,
  output logic [2*AMP_W-1:0]     word_b
);
  localparam int N    = 1 << NODE_BITS;
  localparam int WW   = 2 * AMP_W;
  localparam int FULL = (1 << AMP_W) - 1;

  logic [WW-1:0] rom [N];

  for (genvar w = 0; w < N; w++) begin : g_word
    localparam int LO = hsi_pkg::node_code(w, N, FULL);
    localparam int HI = hsi_pkg::node_code(w + 1, N, FULL);
    assign rom[w] = {AMP_W'(HI), AMP_W'(LO)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
    end else if (rd_en) begin
      word_a <= rom[addr_a];
      word_b <= rom[addr_b];
    end
  end
endmodule

// File: rtl/hsi_poly.sv
module hsi_poly #(
  parameter int FRAC_W = 10,
  parameter int BW     = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en0,
  input  logic                  en1,
  input  logic [FRAC_W-1:0]     frac,
  output logic signed [BW-1:0]  h00,
  output logic signed [BW-1:0]  h10,
  output logic signed [BW-1:0]  h01,
  output logic signed [BW-1:0]  h11
);
  localparam int BF = 2 * FRAC_W;

  logic [FRAC_W-1:0] p1_t, p2_t;
  logic [BF-1:0]     p1_t2, p2_t2, p2_t3;
  logic [BF-1:0]     t2_d, t3_d;

  always_comb begin
    t2_d = BF'(frac) * BF'(frac);
    t3_d = BF'(((3*FRAC_W)'(p1_t2) * (3*FRAC_W)'(p1_t)) >> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_t  <= '0;
      p1_t2 <= '0;
    end else if (en0) begin
      p1_t  <= frac;
      p1_t2 <= t2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_t  <= '0;
      p2_t2 <= '0;
      p2_t3 <= '0;
    end else if (en1) begin
      p2_t  <= p1_t;
      p2_t2 <= p1_t2;
      p2_t3 <= t3_d;
    end
  end

  // basis weights, all with BF fraction bits
  logic signed [BW-1:0] s_t, s_t2, s_t3, s_one;
  always_comb begin
    s_t   = BW'({p2_t, {FRAC_W{1'b0}}});
    s_t2  = BW'(p2_t2);
    s_t3  = BW'(p2_t3);
    s_one = BW'(1) <<< BF;
    h00   = 2 * s_t3 - 3 * s_t2 + s_one;
    h10   = s_t3 - 2 * s_t2 + s_t;
    h01   = 3 * s_t2 - 2 * s_t3;
    h11   = s_t3 - s_t2;
  end

  // R2: the powers of t shrink as the exponent grows
  a_r2_power_order: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_t3 <= p2_t2) && (p2_t2 <= {p2_t, {FRAC_W{1'b0}}}));
endmodule

// File: rtl/hsi_accum.sv
module hsi_accum #(
  parameter int AMP_W = 13,
  parameter int BW    = 23,
  parameter int BF    = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_prod,
  input  logic                  en_out,
  input  logic                  neg,
  input  logic [AMP_W-1:0]      y0,
  input  logic [AMP_W-1:0]      y1,
  input  logic [AMP_W-1:0]      m0,
  input  logic [AMP_W-1:0]      m1,
  input  logic signed [BW-1:0]  h00,
  input  logic signed [BW-1:0]  h10,
  input  logic signed [BW-1:0]  h01,
  input  logic signed [BW-1:0]  h11,
  output logic signed [AMP_W:0] out_sample
);
  localparam int PW    = AMP_W + 1 + BW;
  localparam int AW    = PW + 2;
  localparam int MAXV  = (1 << AMP_W) - 1;

  logic signed [PW-1:0] pr0, pr1, pr2, pr3;
  logic signed [PW-1:0] pr0_d, pr1_d, pr2_d, pr3_d;
  logic signed [AW-1:0] acc, lvl;
  logic [AMP_W-1:0]     mag;
  logic signed [AMP_W:0] res_d;

  always_comb begin
    pr0_d = PW'($signed({1'b0, y0})) * PW'(h00);
    pr1_d = PW'($signed({1'b0, m0})) * PW'(h10);
    pr2_d = PW'($signed({1'b0, y1})) * PW'(h01);
    pr3_d = PW'($signed({1'b0, m1})) * PW'(h11);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr0 <= '0; pr1 <= '0; pr2 <= '0; pr3 <= '0;
    end else if (en_prod) begin
      pr0 <= pr0_d; pr1 <= pr1_d; pr2 <= pr2_d; pr3 <= pr3_d;
    end
  end

  always_comb begin
    acc = AW'(pr0) + AW'(pr1) + AW'(pr2) + AW'(pr3);
    lvl = (acc + (AW'(1) <<< (BF - 1))) >>> BF;
    if (lvl < 0)                mag = '0;
    else if (lvl > AW'(MAXV))   mag = AMP_W'(MAXV);
    else                        mag = lvl[AMP_W-1:0];
    res_d = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_sample <= '0;
    else if (en_out) out_sample <= res_d;
  end

  // R5: never beyond symmetric full scale
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sample <= $signed((AMP_W+1)'(MAXV))) && (out_sample >= -$signed((AMP_W+1)'(MAXV))));
  // R8: no load, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_out |=> $stable(out_sample));
endmodule

// File: rtl/hermite_sine_interp.sv
module hermite_sine_interp #(
  parameter int NODE_BITS = 4,
  parameter int FRAC_W    = 10,
  parameter int OUT_W     = 14,
  parameter int SLOPE_FW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NODE_BITS-1:0]     in_val_addr,
  input  logic [NODE_BITS-1:0]     in_slope_addr,
  input  logic [FRAC_W-1:0]        in_frac,
  input  logic                     in_neg,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int N     = 1 << NODE_BITS;
  localparam int AMP_W = OUT_W - 1;
  localparam int WW    = 2 * AMP_W;
  localparam int BF    = 2 * FRAC_W;
  localparam int BW    = BF + 3;
  localparam int MW    = AMP_W + SLOPE_FW + 1;
  localparam int HQ    = hsi_pkg::width_code(N, SLOPE_FW);

  logic [WW-1:0]    word_a, word_b;
  logic             v1, v2, v3;
  logic             n1, n2, n3;
  logic [AMP_W-1:0] y0_q, y1_q, m0_q, m1_q;
  logic [AMP_W-1:0] y0_d, y1_d, m0_d, m1_d;
  logic signed [BW-1:0] h00, h10, h01, h11;

  function automatic logic [AMP_W-1:0] to_slope(logic [AMP_W-1:0] c);
    return AMP_W'((MW'(c) * MW'(HQ) + (MW'(1) << (SLOPE_FW - 1))) >> SLOPE_FW);
  endfunction

  hsi_qrom #(.NODE_BITS(NODE_BITS), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_en(in_valid),
    .addr_a(in_val_addr), .addr_b(in_slope_addr),
    .word_a(word_a), .word_b(word_b)
  );

  hsi_poly #(.FRAC_W(FRAC_W), .BW(BW)) u_poly (
    .clk(clk), .rst_n(rst_n), .en0(in_valid), .en1(v1), .frac(in_frac),
    .h00(h00), .h10(h10), .h01(h01), .h11(h11)
  );

  // split packed words: value port gives nodes, slope port gives mirrored nodes
  always_comb begin
    y0_d = word_a[AMP_W-1:0];
    y1_d = word_a[WW-1:AMP_W];
    m0_d = to_slope(word_b[WW-1:AMP_W]);
    m1_d = to_slope(word_b[AMP_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y0_q <= '0; y1_q <= '0; m0_q <= '0; m1_q <= '0;
    end else if (v1) begin
      y0_q <= y0_d; y1_q <= y1_d; m0_q <= m0_d; m1_q <= m1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0;
      n1 <= 1'b0; n2 <= 1'b0; n3 <= 1'b0;
    end else begin
      v1 <= in_valid; v2 <= v1; v3 <= v2; out_valid <= v3;
      if (in_valid) n1 <= in_neg;
      if (v1)       n2 <= n1;
      if (v2)       n3 <= n2;
    end
  end

  hsi_accum #(.AMP_W(AMP_W), .BW(BW), .BF(BF)) u_acc (
    .clk(clk), .rst_n(rst_n), .en_prod(v2), .en_out(v3), .neg(n3),
    .y0(y0_q), .y1(y1_q), .m0(m0_q), .m1(m1_q),
    .h00(h00), .h10(h10), .h01(h01), .h11(h11),
    .out_sample(out_sample)
  );

  // R6: fixed four-cycle spacing between request and result
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);
  // R4: a nonzero result carries the requested sign
  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sample != 0) |-> (out_sample[OUT_W-1] == $past(in_neg, 4)));
endmodule

// File: tb/hermite_sine_interp_bench.sv
module hermite_sine_interp_bench;
  localparam int NB = 4;
  localparam int N  = 1 << NB;
  localparam int FW = 10;
  localparam int OW = 14;
  localparam real PI = 3.14159265358979323846;
  localparam real H  = PI / (2.0 * N);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [NB-1:0] in_val_addr, in_slope_addr;
  logic [FW-1:0] in_frac;
  logic in_neg;
  logic out_valid;
  logic signed [OW-1:0] out_sample;

  hermite_sine_interp u_hermite_sine_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_val_addr(in_val_addr),
    .in_slope_addr(in_slope_addr), .in_frac(in_frac), .in_neg(in_neg),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int expv; int tol; string tag; int issued; bit lat; } item_t;
  item_t sb[$];

  function automatic int tabv(int k);
    return $rtoi($floor($sin(PI * k / (2.0 * N)) * 8191.0 + 0.5));
  endfunction

  function automatic int clamp_round(real p);
    int r;
    r = $rtoi($floor(p + 0.5));
    if (r < 0) r = 0;
    if (r > 8191) r = 8191;
    return r;
  endfunction

  function automatic int herm(int a, int b, int f);
    real s, y0, y1, m0, m1, p;
    s  = f / 1024.0;
    y0 = tabv(a); y1 = tabv(a + 1);
    m0 = H * tabv(b + 1); m1 = H * tabv(b);
    p  = (2*s*s*s - 3*s*s + 1) * y0 + (s*s*s - 2*s*s + s) * m0
       + (3*s*s - 2*s*s*s) * y1 + (s*s*s - s*s) * m1;
    return clamp_round(p);
  endfunction

  function automatic int ideal(int k, int f);
    return clamp_round($sin((k + f / 1024.0) * H) * 8191.0);
  endfunction

  task automatic check(string tag, int act, int expv, int tol);
    int d;
    d = act - expv;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, expv, tol);
    end
  endtask

  task automatic send(int a, int b, int f, bit neg, int mag, int tol, string tag, bit lat);
    item_t it;
    @(posedge clk); #1;
    in_valid = 1'b1; in_val_addr = NB'(a); in_slope_addr = NB'(b);
    in_frac = FW'(f); in_neg = neg;
    it.expv = neg ? -mag : mag; it.tol = tol; it.tag = tag; it.issued = cyc; it.lat = lat;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6: actual unexpected output %0d expected none", out_sample);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, int'(out_sample), it.expv, it.tol);
        if (it.lat) check("R6 latency", cyc - it.issued, 4, 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int held;
    rst_n = 1'b0; in_valid = 1'b0; in_val_addr = '0; in_slope_addr = '0;
    in_frac = '0; in_neg = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R7 valid in reset", int'(out_valid), 0, 0);
    check("R7 sample in reset", int'(out_sample), 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R7 valid after reset", int'(out_valid), 0, 0);
    check("R7 sample after reset", int'(out_sample), 0, 0);

    // R1: node values exact, back-to-back stream (R6 latency too)
    for (int k = 0; k < N; k++) send(k, N-1-k, 0, 1'b0, tabv(k), 0, "R1 node", 1'b1);
    // R4: negated nodes exact
    for (int k = 1; k < N; k += 5) send(k, N-1-k, 0, 1'b1, tabv(k), 0, "R4 negated node", 1'b0);
    // R2: offsets inside every interval against the ideal sine
    for (int k = 0; k < N; k++) begin
      send(k, N-1-k, 256, 1'b0, ideal(k, 256), 2, "R2 quarter", 1'b0);
      send(k, N-1-k, 777, k[0], ideal(k, 777), 2, "R2 odd offset / R4 sign", 1'b0);
      send(k, N-1-k, 1023, 1'b0, ideal(k, 1023), 2, "R2 last offset", 1'b0);
    end
    idle(3);
    // R3: slope port decoupled from value port
    send(5, 2, 512, 1'b0, herm(5, 2, 512), 2, "R3 mismatched slopes", 1'b0);
    send(9, 12, 200, 1'b0, herm(9, 12, 200), 2, "R3 mismatched slopes", 1'b0);
    send(3, 3, 600, 1'b1, herm(3, 3, 600), 2, "R3 mismatched slopes", 1'b0);
    // R5: overshoot clamped at full scale, both signs
    send(N-1, N-1, 341, 1'b0, 8191, 0, "R5 clamp", 1'b0);
    send(N-1, N-1, 341, 1'b1, 8191, 0, "R5 clamp negative", 1'b0);
    send(N-1, 0, 1000, 1'b0, herm(N-1, 0, 1000), 2, "R5 near peak", 1'b0);
    idle(1);
    // R6: an isolated request
    send(7, N-8, 100, 1'b0, ideal(7, 100), 2, "R2 isolated", 1'b1);
    idle(8);
    // R8: output held across idle cycles
    @(negedge clk);
    held = int'(out_sample);
    repeat (6) @(negedge clk);
    check("R8 hold sample", int'(out_sample), held, 0);
    check("R8 no valid when idle", int'(out_valid), 0, 0);
    check("R6 all results returned", sb.size(), 0, 0);
    finish_run();
  end
endmodule